// File: doc/BRIEF.md
# Double-Buffered DMA Channel

This block is one DMA channel that moves data between a memory port and a peripheral data port, one device-width unit at a time. It holds two buffer descriptors, each with a start address and a unit count. The channel works through the active buffer. When that buffer runs out it marks the buffer done, disables it and switches the active-buffer indicator to the other buffer. If the other buffer is enabled, the channel carries straight on with it. Software refills the buffer that has just finished while the other one runs, so a stream can continue with no gap.

Software programs the channel through a small register block. The mode word has one address that sets bits and a second address that clears them, so single bits change without a read-modify-write. A stop is a handshake. Software clears the go bit, waits until the halted status reads 1, and only then changes the buffers. The memory side is a single-beat request/acknowledge port. The peripheral side is a request/acknowledge handshake to a fixed peripheral address.

Top module: `dbuf_dma_chan`

## Requirements
- R1: A register write to offset 0x00 ORs its data into the mode word, and a write to offset 0x04 clears every mode bit that is 1 in its data. Reading offset 0x00 returns the mode word. Bit 6 (halted), bit 14 and bits 31:24 cannot be written and read back as 0, apart from bit 6, which shows the status.
- R2: The mode word bit map is as follows. Bit 0 and bit 2 enable buffers 0 and 1. Bit 1 and bit 3 are the done flags of buffers 0 and 1. Bit 4 selects the active buffer (0 = buffer 0). Bit 5 is go, bit 6 is halted, bit 7 is interrupt enable and bit 12 is direction. Bits 10:9 give the device width (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). Bits 8, 11, 13, 15 and 23:16 are stored and read back only. After reset the mode word reads 0x00000040 and every other register reads 0.
- R3: Offset 0x08 holds the peripheral address. Offsets 0x0C and 0x14 hold the start addresses of buffers 0 and 1. Offsets 0x10 and 0x18 hold their count words, with the unit count in bits 15:0 and four stored high-address bits in bits 19:16. Bits 31:20 of a count word read 0.
- R4: When direction is 0, each unit is a memory read at the active start address, followed by a peripheral write of the same data to the peripheral address. When direction is 1, each unit is a peripheral read, followed by a memory write of that data at the active start address.
- R5: After each unit, the active buffer's count drops by 1 and its start address rises by the device width in bytes. The count word therefore always shows the units that remain.
- R6: When go is set and the active buffer is enabled with a count of 0, the channel completes that buffer. It sets the buffer's done flag, clears its enable and inverts bit 4. It then continues with the other buffer if that buffer is enabled. Otherwise it halts.
- R7: An enabled buffer whose count is already 0 completes without any memory or peripheral request.
- R8: Bit 6 reads 0 while the channel runs. After go is cleared, the unit in progress finishes, no new request follows, bit 6 reads 1, and the count word holds the units left.
- R9: A done flag is cleared only by a write to offset 0x04 with that bit set. Both done flags can be set at the same time.
- R10: irq_o is 1 exactly when bit 7 is set and at least one done flag is set.
- R11: mem_req_o and per_req_o each stay high until the matching acknowledge, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory access accepted |
| per_req_o | output | 1 | Peripheral access request |
| per_we_o | output | 1 | Peripheral access is a write |
| per_addr_o | output | ADDR_W | Peripheral data port address |
| per_wdata_o | output | DATA_W | Peripheral write data |
| per_rdata_i | input | DATA_W | Peripheral read data, valid with ack |
| per_ack_i | input | 1 | Peripheral access accepted |
| irq_o | output | 1 | Buffer-done interrupt |

## Verification
Some properties are checked in every cycle. The halted flag appears only while the engine is idle, and it always follows a cycle that is idle with go clear. A count never steps below zero. A done flag never falls unless a clear write carries its bit. A completion always leaves its done flag set. Each request stays high until its acknowledge arrives. Other behaviour shows up only in the bench scenarios: the order of buffers and addresses across a full ping-pong run, data passing the right way for each direction, the width-scaled address steps, the residual count after a stop in mid-stream, and the register map itself.

// File: rtl/dbuf_dma_pkg.sv
`timescale 1ns/1ps
package dbuf_dma_pkg;
  localparam int NBUF = 2;

  localparam logic [4:0] OFS_MODE_SET = 5'h00;
  localparam logic [4:0] OFS_MODE_CLR = 5'h04;
  localparam logic [4:0] OFS_PADDR    = 5'h08;
  localparam logic [4:0] OFS_START0   = 5'h0C;
  localparam logic [4:0] OFS_COUNT0   = 5'h10;
  localparam logic [4:0] OFS_START1   = 5'h14;
  localparam logic [4:0] OFS_COUNT1   = 5'h18;

  localparam int B_EN0  = 0;
  localparam int B_DN0  = 1;
  localparam int B_EN1  = 2;
  localparam int B_DN1  = 3;
  localparam int B_AB   = 4;
  localparam int B_GO   = 5;
  localparam int B_HALT = 6;
  localparam int B_IE   = 7;
  localparam int B_DWLO = 9;
  localparam int B_DIR  = 12;

  // writable bits: everything in 23:0 except halted status and bit 14
  localparam logic [31:0] MODE_WMASK = 32'h00FF_BFBF;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} eng_st_e;
endpackage

// File: rtl/dbuf_dma_desc.sv
`timescale 1ns/1ps
module dbuf_dma_desc
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int HI_W   = 4,
  parameter int IDX    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [4:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              adv_i,
  input  logic [2:0]        inc_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [HI_W-1:0]   hi_o
);
  localparam logic [4:0] START_OFS = (IDX == 0) ? OFS_START0 : OFS_START1;
  localparam logic [4:0] CNT_OFS   = (IDX == 0) ? OFS_COUNT0 : OFS_COUNT1;

  logic [ADDR_W-1:0] start_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
    end else if (we_i && addr_i == START_OFS) begin
      start_q <= wdata_i[ADDR_W-1:0];
    end else if (adv_i) begin
      start_q <= start_q + ADDR_W'(inc_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_q  <= '0;
    end else if (we_i && addr_i == CNT_OFS) begin
      cnt_q <= wdata_i[CNT_W-1:0];
      hi_q  <= wdata_i[CNT_W+HI_W-1:CNT_W];
    end else if (adv_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign start_o = start_q;
  assign cnt_o   = cnt_q;
  assign hi_o    = hi_q;

  // R5: a unit is never charged to an empty buffer
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> cnt_q != '0)
    else $error("count underflow on buffer %0d", IDX);
endmodule

// File: rtl/dbuf_dma_engine.sv
`timescale 1ns/1ps
module dbuf_dma_engine
  import dbuf_dma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              act_en_i,
  input  logic              cnt_zero_i,
  input  logic              dir_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              per_req_o,
  output logic              per_we_o,
  output logic [DATA_W-1:0] per_wdata_o,
  input  logic [DATA_W-1:0] per_rdata_i,
  input  logic              per_ack_i,
  output logic              unit_done_o,
  output logic              complete_o,
  output logic              halt_o
);
  eng_st_e           st_q, st_d;
  logic              dir_q;
  logic [DATA_W-1:0] data_q;
  logic              halt_q;
  logic              run_ok, first_ack, second_ack, launch;

  assign run_ok     = go_i && act_en_i;
  assign first_ack  = dir_q ? per_ack_i : mem_ack_i;
  assign second_ack = dir_q ? mem_ack_i : per_ack_i;
  assign launch     = st_q == ST_IDLE && run_ok && !cnt_zero_i;

  always_comb begin
    st_d        = st_q;
    complete_o  = 1'b0;
    unit_done_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (run_ok && cnt_zero_i) complete_o = 1'b1;
        else if (run_ok)          st_d = ST_FIRST;
      end
      ST_FIRST:  if (first_ack) st_d = ST_SECOND;
      ST_SECOND: begin
        if (second_ack) begin
          unit_done_o = 1'b1;
          st_d        = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dir_q  <= 1'b0;
      data_q <= '0;
      halt_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      halt_q <= (st_d == ST_IDLE) && !run_ok;
      if (launch) dir_q <= dir_i;
      if (st_q == ST_FIRST && first_ack) data_q <= dir_q ? per_rdata_i : mem_rdata_i;
    end
  end

  // direction 0: memory read then peripheral write; direction 1: the reverse
  assign mem_req_o   = (st_q == ST_FIRST && !dir_q) || (st_q == ST_SECOND && dir_q);
  assign per_req_o   = (st_q == ST_FIRST && dir_q)  || (st_q == ST_SECOND && !dir_q);
  assign mem_we_o    = st_q == ST_SECOND;
  assign per_we_o    = st_q == ST_SECOND;
  assign mem_wdata_o = data_q;
  assign per_wdata_o = data_q;
  assign halt_o      = halt_q;

  assert_halt_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> st_q == ST_IDLE)
    else $error("halted while a unit is in flight");

  assert_halt_after_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !go_i) |=> halt_o)
    else $error("halted not reported after stop");

  assert_mem_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o)
    else $error("memory request dropped before ack");

  assert_per_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_req_o && !per_ack_i) |=> per_req_o)
    else $error("peripheral request dropped before ack");
endmodule

// File: rtl/dbuf_dma_regs.sv
`timescale 1ns/1ps
module dbuf_dma_regs
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int HI_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [4:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              unit_done_i,
  input  logic              complete_i,
  input  logic              halt_i,
  output logic              go_o,
  output logic              act_en_o,
  output logic              cnt_zero_o,
  output logic              dir_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] per_addr_o
);
  logic [31:0]       mode_q, mode_hw, mode_d;
  logic [ADDR_W-1:0] paddr_q;
  logic              ab, set_wr, clr_wr;
  logic [1:0]        dw;
  logic [2:0]        inc;
  logic [ADDR_W-1:0] start_w [NBUF];
  logic [CNT_W-1:0]  cnt_w   [NBUF];
  logic [HI_W-1:0]   hi_w    [NBUF];

  assign ab     = mode_q[B_AB];
  assign set_wr = we_i && addr_i == OFS_MODE_SET;
  assign clr_wr = we_i && addr_i == OFS_MODE_CLR;
  assign dw     = mode_q[B_DWLO+1:B_DWLO];
  assign inc    = (dw == 2'd0) ? 3'd1 : (dw == 2'd1) ? 3'd2 : 3'd4;

  always_comb begin
    mode_hw = mode_q;
    if (complete_i) begin
      if (ab) begin
        mode_hw[B_DN1] = 1'b1;
        mode_hw[B_EN1] = 1'b0;
      end else begin
        mode_hw[B_DN0] = 1'b1;
        mode_hw[B_EN0] = 1'b0;
      end
      mode_hw[B_AB] = ~ab;
    end
    mode_d = mode_hw;
    if (set_wr)      mode_d = mode_hw | (wdata_i & MODE_WMASK);
    else if (clr_wr) mode_d = mode_hw & ~(wdata_i & MODE_WMASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      paddr_q <= '0;
    end else begin
      mode_q <= mode_d;
      if (we_i && addr_i == OFS_PADDR) paddr_q <= wdata_i[ADDR_W-1:0];
    end
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    localparam int DN = (b == 0) ? B_DN0 : B_DN1;

    dbuf_dma_desc #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .HI_W(HI_W), .IDX(b)
    ) i_desc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .adv_i   (unit_done_i && ab == 1'(b)),
      .inc_i   (inc),
      .start_o (start_w[b]),
      .cnt_o   (cnt_w[b]),
      .hi_o    (hi_w[b])
    );

    assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(mode_q[DN]) |-> $past(clr_wr && wdata_i[DN]))
      else $error("done flag %0d dropped without a clear write", b);

    assert_done_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (complete_i && ab == 1'(b) && !(clr_wr && wdata_i[DN])) |=> mode_q[DN])
      else $error("completion did not leave done flag %0d set", b);
  end

  assign go_o       = mode_q[B_GO];
  assign act_en_o   = ab ? mode_q[B_EN1] : mode_q[B_EN0];
  assign cnt_zero_o = cnt_w[ab] == '0;
  assign dir_o      = mode_q[B_DIR];
  assign irq_o      = mode_q[B_IE] && (mode_q[B_DN0] || mode_q[B_DN1]);
  assign mem_addr_o = start_w[ab];
  assign per_addr_o = paddr_q;

  always_comb begin
    unique case (addr_i)
      OFS_MODE_SET: rdata_o = mode_q | (32'(halt_i) << B_HALT);
      OFS_PADDR:    rdata_o = 32'(paddr_q);
      OFS_START0:   rdata_o = 32'(start_w[0]);
      OFS_COUNT0:   rdata_o = 32'({hi_w[0], cnt_w[0]});
      OFS_START1:   rdata_o = 32'(start_w[1]);
      OFS_COUNT1:   rdata_o = 32'({hi_w[1], cnt_w[1]});
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dbuf_dma_chan.sv
`timescale 1ns/1ps
module dbuf_dma_chan
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int HI_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              per_req_o,
  output logic              per_we_o,
  output logic [ADDR_W-1:0] per_addr_o,
  output logic [DATA_W-1:0] per_wdata_o,
  input  logic [DATA_W-1:0] per_rdata_i,
  input  logic              per_ack_i,
  output logic              irq_o
);
  logic go, act_en, cnt_zero, dir, unit_done, complete, halt;

  dbuf_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .HI_W(HI_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .unit_done_i (unit_done),
    .complete_i  (complete),
    .halt_i      (halt),
    .go_o        (go),
    .act_en_o    (act_en),
    .cnt_zero_o  (cnt_zero),
    .dir_o       (dir),
    .irq_o       (irq_o),
    .mem_addr_o  (mem_addr_o),
    .per_addr_o  (per_addr_o)
  );

  dbuf_dma_engine #(.DATA_W(DATA_W)) i_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .act_en_i    (act_en),
    .cnt_zero_i  (cnt_zero),
    .dir_i       (dir),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .per_req_o   (per_req_o),
    .per_we_o    (per_we_o),
    .per_wdata_o (per_wdata_o),
    .per_rdata_i (per_rdata_i),
    .per_ack_i   (per_ack_i),
    .unit_done_o (unit_done),
    .complete_o  (complete),
    .halt_o      (halt)
  );

  assert_one_side_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && per_req_o))
    else $error("memory and peripheral requested together");
endmodule

// File: tb/test_dbuf_dma_chan.sv
`timescale 1ns/1ps
module test_dbuf_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        per_req, per_we, per_ack = 1'b0;
  logic [31:0] per_addr, per_wdata, per_rdata = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  bit stall = 1'b0;
  logic [31:0] cyc = '0;

  logic [31:0] m_addr [256];
  logic [31:0] m_data [256];
  logic        m_we   [256];
  logic [31:0] p_addr [256];
  logic [31:0] p_data [256];
  logic        p_we   [256];
  int m_n = 0;
  int p_n = 0;
  int p_seq = 0;

  always #2 clk = ~clk;

  dbuf_dma_chan i_dbuf_dma_chan (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .per_req_o(per_req), .per_we_o(per_we), .per_addr_o(per_addr), .per_wdata_o(per_wdata),
    .per_rdata_i(per_rdata), .per_ack_i(per_ack),
    .irq_o(irq)
  );

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return a * 32'd3 + 32'h5A00_0007;
  endfunction

  // responders: ack decided at negedge, transfer takes effect at the next posedge
  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_ack = mem_req && !(stall && cyc[0]);
    per_ack = per_req && !(stall && cyc[1]);
    if (mem_ack && m_n < 256) begin
      if (!mem_we) mem_rdata = mem_val(mem_addr);
      m_addr[m_n] = mem_addr;
      m_we[m_n]   = mem_we;
      m_data[m_n] = mem_we ? mem_wdata : mem_rdata;
      m_n++;
    end
    if (per_ack && p_n < 256) begin
      if (!per_we) begin
        per_rdata = 32'h1000 + 32'(p_seq);
        p_seq++;
      end
      p_addr[p_n] = per_addr;
      p_we[p_n]   = per_we;
      p_data[p_n] = per_we ? per_wdata : per_rdata;
      p_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_halt(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4000; i++) begin
      rd(5'h00, v);
      if (v[6]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic clear_logs();
    m_n = 0; p_n = 0; p_seq = 0;
  endtask

  // full ping-pong run: R4 R5 R6 R10
  task automatic run_pair(input int run, input int dw, input bit dir, input bit ie, input bit ab0,
                          input int n0, input int n1);
    logic [31:0] s0, s1, pa, v, exp_a, exp_d, b;
    logic [3:0] h0, h1;
    bit ok, good;
    int tot, k, first_n;
    b  = 32'd1 << dw;
    s0 = 32'h0000_1000 + 32'(run) * 32'h100;
    s1 = 32'h0000_8000 + 32'(run) * 32'h100;
    pa = 32'hF000_0000 + 32'(run);
    h0 = 4'(run);
    h1 = 4'(15 - run);
    stall = run[0] ^ run[2];
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h08, pa);
    wr(5'h0C, s0);
    wr(5'h10, {12'h0, h0, 16'(n0)});
    wr(5'h14, s1);
    wr(5'h18, {12'h0, h1, 16'(n1)});
    wr(5'h00, (32'(dw) << 9) | (32'(dir) << 12) | (32'(ie) << 7) | (32'(ab0) << 4) | 32'h5);
    clear_logs();
    wr(5'h00, 32'h20);
    wait_halt(ok);
    check(ok, $sformatf("R8 run%0d halted after both buffers", run), 32'(ok), 32'd1);
    tot = n0 + n1;
    check(m_n == tot && p_n == tot, $sformatf("R6 run%0d unit count", run), 32'(m_n), 32'(tot));
    good = 1'b1;
    first_n = ab0 ? n1 : n0;
    for (k = 0; k < tot && k < m_n && k < p_n; k++) begin
      if (k < first_n) exp_a = (ab0 ? s1 : s0) + 32'(k) * b;
      else             exp_a = (ab0 ? s0 : s1) + 32'(k - first_n) * b;
      exp_d = dir ? 32'h1000 + 32'(k) : mem_val(exp_a);
      if (m_addr[k] != exp_a || m_data[k] != exp_d || p_data[k] != exp_d ||
          p_addr[k] != pa || m_we[k] != dir || p_we[k] != !dir) begin
        if (good) $display("FAIL R4 R5 run%0d unit%0d actual=%h expected=%h",
                           run, k, m_addr[k], exp_a);
        good = 1'b0;
      end
    end
    checks++;
    if (!good) errors++;
    rd(5'h00, v);
    exp_d = 32'h0000_006A | (32'(dw) << 9) | (32'(dir) << 12) | (32'(ie) << 7) | (32'(ab0) << 4);
    check(v == exp_d, $sformatf("R6 run%0d final mode", run), v, exp_d);
    rd(5'h10, v);
    check(v == {12'h0, h0, 16'h0}, $sformatf("R5 run%0d count0 drained", run), v, {12'h0, h0, 16'h0});
    rd(5'h18, v);
    check(v == {12'h0, h1, 16'h0}, $sformatf("R5 run%0d count1 drained", run), v, {12'h0, h1, 16'h0});
    rd(5'h0C, v);
    check(v == s0 + 32'(n0) * b, $sformatf("R5 run%0d start0 advanced", run), v, s0 + 32'(n0) * b);
    rd(5'h14, v);
    check(v == s1 + 32'(n1) * b, $sformatf("R5 run%0d start1 advanced", run), v, s1 + 32'(n1) * b);
    #1;
    check(irq == ie, $sformatf("R10 run%0d irq", run), 32'(irq), 32'(ie));
    stall = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    bit ok;
    int run, units, m_before, p_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(5'h00, v); check(v == 32'h40, "R2 mode after reset", v, 32'h40);
    rd(5'h10, v); check(v == 32'h0, "R2 count0 after reset", v, 32'h0);
    rd(5'h14, v); check(v == 32'h0, "R2 start1 after reset", v, 32'h0);
    #1; check(irq == 1'b0, "R2 irq after reset", 32'(irq), 32'h0);

    // R1 set/clear semantics (go excluded so nothing starts)
    wr(5'h00, 32'hFFFF_FFDF);
    rd(5'h00, v); check(v == 32'h00FF_BFDF, "R1 set all but go", v, 32'h00FF_BFDF);
    wr(5'h04, 32'h0000_0A00);
    rd(5'h00, v); check(v == 32'h00FF_B5DF, "R1 partial clear", v, 32'h00FF_B5DF);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h00, v); check(v == 32'h40, "R1 clear all keeps halted", v, 32'h40);
    wr(5'h00, 32'h0000_0000);
    rd(5'h00, v); check(v == 32'h40, "R1 set with zero data", v, 32'h40);
    rd(5'h04, v); check(v == 32'h0, "R1 clear offset reads zero", v, 32'h0);

    // R3 register map
    wr(5'h08, 32'hC0DE_0008);
    wr(5'h0C, 32'h1234_5670);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h14, 32'hABCD_EF00);
    wr(5'h18, 32'h0003_0007);
    rd(5'h08, v); check(v == 32'hC0DE_0008, "R3 peripheral address", v, 32'hC0DE_0008);
    rd(5'h0C, v); check(v == 32'h1234_5670, "R3 start0", v, 32'h1234_5670);
    rd(5'h10, v); check(v == 32'h000F_FFFF, "R3 count0 field width", v, 32'h000F_FFFF);
    rd(5'h14, v); check(v == 32'hABCD_EF00, "R3 start1", v, 32'hABCD_EF00);
    rd(5'h18, v); check(v == 32'h0003_0007, "R3 count1", v, 32'h0003_0007);

    // sweep over width, direction, interrupt enable, starting buffer
    run = 0;
    for (int dw = 0; dw < 3; dw++)
      for (int dir = 0; dir < 2; dir++)
        for (int ie = 0; ie < 2; ie++)
          for (int ab0 = 0; ab0 < 2; ab0++) begin
            run_pair(run, dw, dir[0], ie[0], ab0[0], 1 + (run % 4), 2 + (run % 3));
            run++;
          end

    // R9 done flags sticky, clear individually; R10 irq follows
    wr(5'h00, 32'h0000_0080);
    rd(5'h00, v); check(v[3:1] == 3'b101, "R9 both done flags set together", 32'(v[3:1]), 32'h5);
    wr(5'h04, 32'h0000_0000);
    rd(5'h00, v); check(v[3] && v[1], "R9 zero clear write keeps done", v, 32'h0A);
    wr(5'h04, 32'h0000_0002);
    rd(5'h00, v); check(!v[1] && v[3], "R9 clear done0 only", v, 32'h08);
    #1; check(irq == 1'b1, "R10 irq with done1 and enable", 32'(irq), 32'h1);
    wr(5'h04, 32'h0000_0080);
    #1; check(irq == 1'b0, "R10 irq masked by enable", 32'(irq), 32'h0);
    wr(5'h00, 32'h0000_0080);
    wr(5'h04, 32'h0000_0008);
    #1; check(irq == 1'b0, "R10 irq with no done flag", 32'(irq), 32'h0);

    // R7 zero-count buffer completes without traffic
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0);
    wr(5'h00, 32'h1);
    clear_logs();
    wr(5'h00, 32'h20);
    wait_halt(ok);
    rd(5'h00, v);
    check(v == 32'h0000_0072, "R7 zero count completes", v, 32'h0000_0072);
    check(m_n == 0 && p_n == 0, "R7 no requests for empty buffer", 32'(m_n + p_n), 32'h0);

    // R8 stop in mid-stream
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h08, 32'h0000_0300);
    wr(5'h0C, 32'h0000_4000);
    wr(5'h10, 32'd40);
    wr(5'h00, 32'h0000_0401);
    stall = 1'b1;
    clear_logs();
    wr(5'h00, 32'h20);
    repeat (3) @(negedge clk);
    rd(5'h00, v);
    check(!v[6], "R8 halted reads 0 while running", 32'(v[6]), 32'h0);
    repeat (40) @(negedge clk);
    wr(5'h04, 32'h20);
    wait_halt(ok);
    check(ok, "R8 halted after go cleared", 32'(ok), 32'h1);
    units = p_n;
    check(units > 0 && units < 40 && m_n == units, "R8 whole units only", 32'(m_n), 32'(units));
    rd(5'h10, v);
    check(v == 32'(40 - units), "R8 residual count", v, 32'(40 - units));
    rd(5'h0C, v);
    check(v == 32'h4000 + 32'(units) * 4, "R5 start after stop", v, 32'h4000 + 32'(units) * 4);
    m_before = m_n; p_before = p_n;
    repeat (30) @(negedge clk);
    check(m_n == m_before && p_n == p_before, "R8 no request after halt", 32'(m_n), 32'(m_before));
    rd(5'h00, v);
    check(v == 32'h0000_0441, "R8 mode after stop", v, 32'h0000_0441);
    stall = 1'b0;

    // R6 resume: remaining units then halt with done0 set
    clear_logs();
    wr(5'h00, 32'h20);
    wait_halt(ok);
    check(p_n == 40 - units, "R6 resume drains the rest", 32'(p_n), 32'(40 - units));
    rd(5'h00, v);
    check(v == 32'h0000_0472, "R6 done after resume", v, 32'h0000_0472);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule